// File: doc/BRIEF.md
# Recovered Clock Frequency Lock Detector

This block judges whether a recovered line clock runs at the same frequency as a local reference clock. Each recovered-clock edge reaches the block as a one-cycle strobe in the reference domain, with at most one strobe per reference cycle. The block counts these strobes over a fixed window of reference cycles. At the end of each window it compares the count with the window length. A large deviation raises a loss-of-lock status. A small deviation clears it. Between the two limits the status keeps its value, so it does not chatter near a single threshold.

Loss of lock is never declared from a window during which the reference was reported missing. Every change of the status, in either direction, latches a change flag. Software clears the flag by writing one to it. The interrupt output is the flag gated by an enable. The defaults give a window of 131072 reference cycles. A deviation above 1035 counts (about 7900 ppm) declares loss. A deviation below 1009 counts (about 7700 ppm) clears it.

Top module: `freq_lock_monitor`

## Requirements
- R1: At a window end, if the absolute deviation |strobes counted − WINDOW| is greater than SET_ERR and the reference was present in every cycle of that window, `lossOfLock` becomes 1 on the following clock edge.
- R2: At a window end, if the absolute deviation is less than CLR_ERR and R1 does not apply, `lossOfLock` becomes 0.
- R3: If the deviation lies between CLR_ERR and SET_ERR, both limits included, `lossOfLock` keeps its previous value.
- R4: If `refPresent` is 0 in any cycle of a window, that window cannot set `lossOfLock`. It may still clear it under R2.
- R5: Every change of `lossOfLock`, whether 0→1 or 1→0, sets `changeFlag` on the same clock edge.
- R6: `chgClear` = 1 clears `changeFlag` on the next edge. If a status change happens on that same edge, the flag stays 1.
- R7: `irq` equals `changeFlag` AND `irqEnable` at all times.
- R8: After reset, `lossOfLock`, `changeFlag` and `irq` are 0, and the first window starts on the first clock edge with `rstN` = 1.
- R9: Windows are exactly WINDOW = 2^WIN_LOG2 cycles long and follow each other with no gap. The strobe count restarts at zero after each window, and `lossOfLock` changes only on the edge that ends a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| edgePulse | input | 1 | One-cycle strobe for each recovered-clock edge, already in the reference domain |
| refPresent | input | 1 | 1 while the reference clock is reported present |
| irqEnable | input | 1 | Interrupt enable |
| chgClear | input | 1 | Write-one-to-clear strobe for the change flag |
| lossOfLock | output | 1 | 1 = recovered clock out of lock |
| changeFlag | output | 1 | Latched status-change event |
| irq | output | 1 | Interrupt request |

## Verification
A wrong strobe count or a misplaced window boundary remains hidden until the window closes. It then appears as a wrong `lossOfLock` value on the edge after the last window cycle. Deviations of exactly SET_ERR, SET_ERR+1, CLR_ERR and CLR_ERR−1 are driven to expose off-by-one errors in the counter or the comparators. A fault in the change flag or the interrupt gating appears on the same edge as the status change, or on the edge after a clear. A behavioural model checks all three outputs every cycle, so any divergence is reported in the cycle it first occurs.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef struct packed {
    logic winEnd;   // last cycle of the current measurement window
  } ctrlStrobes_t;

  typedef struct packed {
    logic tooFar;      // deviation above set limit
    logic closeEnough; // deviation below clear limit
  } cmpResult_t;
endpackage

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 17,
  parameter int SET_ERR  = 1035,
  parameter int CLR_ERR  = 1009
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         edgePulse,
  input  ctrlStrobes_t strb,
  output cmpResult_t   cmp
);
  localparam int CW = WIN_LOG2 + 1;
  localparam logic [CW-1:0] WIN_V = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] SET_V = CW'(SET_ERR);
  localparam logic [CW-1:0] CLR_V = CW'(CLR_ERR);

  logic [CW-1:0] edgeCnt;
  logic [CW-1:0] total;
  logic [CW-1:0] deviation;

  assign total = edgeCnt + CW'(edgePulse);

  always_comb begin
    if (total >= WIN_V) deviation = total - WIN_V;
    else                deviation = WIN_V - total;
  end

  assign cmp.tooFar      = deviation > SET_V;
  assign cmp.closeEnough = deviation < CLR_V;

  always_ff @(posedge clk) begin
    if (!rstN)            edgeCnt <= '0;
    else if (strb.winEnd) edgeCnt <= '0;
    else                  edgeCnt <= total;
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt < WIN_V);

  // R9
  count_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.winEnd |=> edgeCnt == '0);
endmodule

// File: rtl/lockdet_control.sv
module lockdet_control
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 17
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refPresent,
  input  logic         irqEnable,
  input  logic         chgClear,
  input  cmpResult_t   cmp,
  output ctrlStrobes_t strb,
  output logic         lossOfLock,
  output logic         changeFlag,
  output logic         irq
);
  logic [WIN_LOG2-1:0] winCnt;
  logic refLost;
  logic refLostAny;
  logic statusNext;
  logic changeEvt;

  assign strb.winEnd = &winCnt;
  assign refLostAny  = refLost | ~refPresent;

  always_comb begin
    statusNext = lossOfLock;
    if (strb.winEnd) begin
      if (cmp.tooFar && !refLostAny) statusNext = 1'b1;
      else if (cmp.closeEnough)      statusNext = 1'b0;
    end
  end

  assign changeEvt = statusNext != lossOfLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt     <= '0;
      refLost    <= 1'b0;
      lossOfLock <= 1'b0;
      changeFlag <= 1'b0;
    end else begin
      winCnt     <= winCnt + 1'b1;
      refLost    <= strb.winEnd ? 1'b0 : refLostAny;
      lossOfLock <= statusNext;
      changeFlag <= changeEvt | (changeFlag & ~chgClear);
    end
  end

  assign irq = changeFlag & irqEnable;

  // R5
  change_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lossOfLock != $past(lossOfLock)) |-> changeFlag);

  // R9
  window_edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.winEnd |=> $stable(lossOfLock));

  // R4
  no_set_without_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winEnd && refLostAny && !lossOfLock) |=> !lossOfLock);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chgClear && !changeEvt) |=> !changeFlag);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (changeFlag && irqEnable));
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 17,
  parameter int SET_ERR  = 1035,
  parameter int CLR_ERR  = 1009
) (
  input  logic clk,
  input  logic rstN,
  input  logic edgePulse,
  input  logic refPresent,
  input  logic irqEnable,
  input  logic chgClear,
  output logic lossOfLock,
  output logic changeFlag,
  output logic irq
);
  ctrlStrobes_t strb;
  cmpResult_t   cmp;

  lockdet_datapath #(
    .WIN_LOG2(WIN_LOG2), .SET_ERR(SET_ERR), .CLR_ERR(CLR_ERR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .edgePulse(edgePulse), .strb(strb), .cmp(cmp)
  );

  lockdet_control #(.WIN_LOG2(WIN_LOG2)) i_ctl (
    .clk(clk), .rstN(rstN), .refPresent(refPresent), .irqEnable(irqEnable),
    .chgClear(chgClear), .cmp(cmp), .strb(strb), .lossOfLock(lossOfLock),
    .changeFlag(changeFlag), .irq(irq)
  );
endmodule

// File: tb/test_freq_lock_monitor.sv
module test_freq_lock_monitor;
  localparam int WL  = 10;
  localparam int WIN = 1 << WL;
  localparam int SET = 40;
  localparam int CLR = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic edgePulse = 1'b0, refPresent = 1'b1, irqEnable = 1'b1, chgClear = 1'b0;
  logic lossOfLock, changeFlag, irq;

  int tests = 0, fails = 0;
  int mCyc = 0, mPulses = 0;
  bit mRefBad = 0, mSt = 0, mFlag = 0;

  always #4 clk = ~clk;

  freq_lock_monitor #(.WIN_LOG2(WL), .SET_ERR(SET), .CLR_ERR(CLR)) i_freq_lock_monitor (
    .clk(clk), .rstN(rstN), .edgePulse(edgePulse), .refPresent(refPresent),
    .irqEnable(irqEnable), .chgClear(chgClear), .lossOfLock(lossOfLock),
    .changeFlag(changeFlag), .irq(irq)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mCyc = 0; mPulses = 0; mRefBad = 0; mSt = 0; mFlag = 0;
    end else begin
      bit ev;
      bit nxt;
      int dev;
      ev = 0;
      mPulses += int'(edgePulse);
      if (!refPresent) mRefBad = 1;
      if (mCyc == WIN - 1) begin
        dev = WIN - mPulses;
        if (dev < 0) dev = -dev;
        nxt = mSt;
        if (dev > SET && !mRefBad) nxt = 1;
        else if (dev < CLR) nxt = 0;
        ev = (nxt != mSt);
        mSt = nxt; mPulses = 0; mRefBad = 0; mCyc = 0;
      end else mCyc++;
      mFlag = ev | (mFlag & !chgClear);
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1,R2,R3,R4,R9", lossOfLock, mSt, "lossOfLock");
    check("R5,R6", changeFlag, mFlag, "changeFlag");
    check("R7", irq, mFlag & irqEnable, "irq");
  endtask

  // one cycle: drive inputs, pass one posedge, compare at negedge
  task automatic step(logic p, logic rp, logic clr);
    edgePulse = p; refPresent = rp; chgClear = clr;
    @(negedge clk);
    compareAll();
  endtask

  // a window with 'drop' missing strobes; optional ref gap cycle and clear at last cycle
  task automatic window(int drop, int gapAt, bit clrLast);
    for (int i = 0; i < WIN; i++)
      step(i >= drop, i != gapAt, clrLast && (i == WIN - 1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", lossOfLock, 1'b0, "reset lossOfLock");
    check("R8", changeFlag, 1'b0, "reset changeFlag");
    check("R8", irq, 1'b0, "reset irq");
    rstN = 1'b1;
    window(0, -1, 0);            // exact match, stays locked
    check("R2", lossOfLock, 1'b0, "zero deviation");
    window(SET, -1, 0);          // boundary: equal to set limit holds
    check("R3", lossOfLock, 1'b0, "dev=SET no set");
    window(SET + 1, -1, 0);      // just above: set
    check("R1", lossOfLock, 1'b1, "dev=SET+1 sets");
    check("R5", changeFlag, 1'b1, "flag after set");
    check("R7", irq, 1'b1, "irq enabled");
    irqEnable = 1'b0;
    step(1, 1, 1);               // W1C clear
    check("R6", changeFlag, 1'b0, "flag cleared");
    check("R7", irq, 1'b0, "irq disabled");
    for (int i = 1; i < WIN; i++) step(1'b1, 1'b1, 1'b0); // rest of window, dev 0 -> clear
    check("R2", lossOfLock, 1'b0, "clear at dev 0");
    check("R5", changeFlag, 1'b1, "flag after clear");
    check("R7", irq, 1'b0, "irq masked");
    irqEnable = 1'b1;
    window(60, 500, 0);          // large dev, ref gap -> no set
    check("R4", lossOfLock, 1'b0, "no set with ref gap");
    window(60, -1, 1);           // set with clear on same edge
    check("R1", lossOfLock, 1'b1, "set dev 60");
    check("R6", changeFlag, 1'b1, "event beats clear");
    window(CLR, -1, 1);          // boundary: equal to clear limit holds
    check("R3", lossOfLock, 1'b1, "dev=CLR holds");
    check("R6", changeFlag, 1'b0, "cleared no event");
    window(30, 10, 0);           // middle band holds
    check("R3", lossOfLock, 1'b1, "mid band holds");
    window(CLR - 1, 100, 0);     // ref gap still allows clear
    check("R2", lossOfLock, 1'b0, "dev=CLR-1 clears");
    check("R4", changeFlag, 1'b1, "clear during gap");
    window(30, -1, 0);
    check("R3", lossOfLock, 1'b0, "mid band holds low");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule